// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This block is the calibration controller for the output drivers of a DDR2-style memory device. Extended mode register writes reach it with a three-bit calibration field. The field moves the controller into one of several states: idle (calibration exit), forced-high drive, forced-low drive, or adjust. The same field can also load the default impedance setting. In the two drive states the block sets the output enables and forced levels for every data lane, every true and complementary strobe, and, when enabled, the read strobes. The memory controller can then measure the driver.

In adjust state the memory controller sends a four-beat code on data lane 0. The block collects the four beats, splits them into a pull-up command and a pull-down command, and steps two separate impedance registers up or down. Both registers saturate at the ends of their range. One setting is shared by all data lanes. A later mode write with an all-zero calibration field leaves the calibrated setting untouched.

Top module: `ocd_drv_cal`

## Requirements
- R1: After a synchronous active-low reset, both impedance steps are 4, the block is idle, every output enable and forced level is 0, and both flags are 0.
- R2: The calibration field is `cal_field` = A9..A7 of a mode write. Code 001 enters drive-high: from the cycle after the write, every `dq_oe`/`dq_lvl` bit is 1, every `dqs_oe`/`dqs_lvl` bit is 1 and every `dqsn_lvl` bit is 0.
- R3: Code 010 enters drive-low: all enables are 1, `dq_lvl` and `dqs_lvl` are 0 and `dqsn_lvl` is 1.
- R4: Every mode write captures `rdqs_en_in`. The read strobes are enabled and follow the `dq_lvl` level in drive states only while that captured bit is 1. Otherwise `rdqs_oe` and `rdqs_lvl` stay 0.
- R5: Code 100 enters adjust only when `bl4_in` is 1. When `bl4_in` is 0 the mode is left unchanged and `bl_err` is set. `bl_err` stays set until reset.
- R6: In adjust state, four `beat_vld` beats on `beat_bit` (lane 0, DT0 first) form one code. The pair {DT0,DT1} controls pull-up and {DT2,DT3} controls pull-down: 01 increments and 10 decrements. The new steps appear two cycles after the edge that takes the last beat. Beats outside adjust state are ignored.
- R7: Each step ranges from 0 to 7. An increment at 7 or a decrement at 0 leaves the step unchanged.
- R8: Code 000 returns the block to idle and keeps both steps unchanged.
- R9: Code 111 returns the block to idle. With `half_in` = 0 it loads step 4 into both registers and clears `dflt_na`. With `half_in` = 1 it leaves the steps unchanged and sets `dflt_na`.
- R10: Codes 011, 101 and 110 leave the mode, the steps and both flags unchanged.
- R11: A pair value of 11 in an adjust code leaves the corresponding step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| emr_wr | input | 1 | Extended mode register write strobe |
| cal_field | input | 3 | Calibration field of the write (A9..A7) |
| rdqs_en_in | input | 1 | Read-strobe enable bit of the write |
| half_in | input | 1 | Half drive strength selected |
| bl4_in | input | 1 | Burst length currently 4 |
| beat_vld | input | 1 | Code beat present on lane 0 |
| beat_bit | input | 1 | Lane 0 value of the beat |
| dq_oe | output | DQ_W | Data lane output enables |
| dq_lvl | output | DQ_W | Data lane forced levels |
| dqs_oe | output | DQS_W | Strobe pair output enables |
| dqs_lvl | output | DQS_W | True strobe forced levels |
| dqsn_lvl | output | DQS_W | Complementary strobe forced levels |
| rdqs_oe | output | DQS_W | Read strobe output enables |
| rdqs_lvl | output | DQS_W | Read strobe forced levels |
| pu_step | output | STEP_W | Pull-up impedance step |
| pd_step | output | STEP_W | Pull-down impedance step |
| adj_active | output | 1 | Adjust state active |
| bl_err | output | 1 | Sticky adjust-rejected flag |
| dflt_na | output | 1 | Last default load not applicable |

## Verification
A mode write is taken at one rising edge. Its effect on the mode, the pin forcing, the flags and any default load is visible from the following cycle. The bench drives at falling edges and checks at the falling edge after the write. An adjust code first passes through a capture register and then through the step registers. For that reason the bench waits two edges past the edge that takes the fourth beat, and only then compares the steps. Because every operation runs to completion before the next begins, the bench model can update its state per operation and compare all outputs at one fixed point.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

  typedef enum logic [1:0] {
    CM_IDLE   = 2'd0,
    CM_DRV_HI = 2'd1,
    CM_DRV_LO = 2'd2,
    CM_ADJ    = 2'd3
  } cal_mode_e;

  typedef enum logic [1:0] {
    SO_HOLD = 2'd0,
    SO_UP   = 2'd1,
    SO_DOWN = 2'd2
  } step_op_e;

  localparam logic [2:0] FLD_EXIT   = 3'b000;
  localparam logic [2:0] FLD_DRV_HI = 3'b001;
  localparam logic [2:0] FLD_DRV_LO = 3'b010;
  localparam logic [2:0] FLD_ADJ    = 3'b100;
  localparam logic [2:0] FLD_DFLT   = 3'b111;

  // Two beats of the code select one step operation; 11 is a hold.
  function automatic step_op_e pair_to_op(input logic [1:0] pair);
    case (pair)
      2'b01:   return SO_UP;
      2'b10:   return SO_DOWN;
      default: return SO_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/ocd_mode_dec.sv
module ocd_mode_dec
  import ocd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [2:0] field,
  input  logic      rdqs_in,
  input  logic      half,
  input  logic      bl4,
  output cal_mode_e mode,
  output logic      rdqs_en_q,
  output logic      err_q,
  output logic      na_q,
  output logic      dflt_load,
  output logic      adj_reject
);

  logic wr_exit, wr_hi, wr_lo, wr_adj, wr_dflt;

  assign wr_exit    = wr && (field == FLD_EXIT);
  assign wr_hi      = wr && (field == FLD_DRV_HI);
  assign wr_lo      = wr && (field == FLD_DRV_LO);
  assign wr_adj     = wr && (field == FLD_ADJ);
  assign wr_dflt    = wr && (field == FLD_DFLT);
  assign adj_reject = wr_adj && !bl4;
  assign dflt_load  = wr_dflt && !half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= CM_IDLE;
      rdqs_en_q <= 1'b0;
      err_q     <= 1'b0;
      na_q      <= 1'b0;
    end else begin
      if (wr) rdqs_en_q <= rdqs_in;
      if (wr_exit || wr_dflt)  mode <= CM_IDLE;
      else if (wr_hi)          mode <= CM_DRV_HI;
      else if (wr_lo)          mode <= CM_DRV_LO;
      else if (wr_adj && bl4)  mode <= CM_ADJ;
      if (adj_reject) err_q <= 1'b1;
      if (wr_dflt)    na_q  <= half;
    end
  end

endmodule

// File: rtl/ocd_code_cap.sv
module ocd_code_cap #(
  parameter int BEATS = 4,
  localparam int CW = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             beat_vld,
  input  logic             beat_bit,
  output logic             code_vld,
  output logic [BEATS-1:0] code
);

  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [CW-1:0]    cnt;
  logic [BEATS-2:0] sh;
  logic             take;

  assign take = arm && beat_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      code     <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      if (!arm) begin
        cnt <= '0;
      end else if (take) begin
        sh <= {sh[BEATS-3:0], beat_bit};
        if (cnt == LAST) begin
          cnt      <= '0;
          code     <= {sh, beat_bit};
          code_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ocd_step_ctr.sv
module ocd_step_ctr #(
  parameter int STEPS = 8,
  parameter int DFLT  = 4,
  localparam int SW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic          dec,
  output logic [SW-1:0] step
);

  localparam logic [SW-1:0] TOP  = SW'(STEPS - 1);
  localparam logic [SW-1:0] INIT = SW'(DFLT);

  function automatic logic [SW-1:0] sat_next(input logic [SW-1:0] cur,
                                             input logic up, input logic dn);
    if (up && cur != TOP)      return cur + 1'b1;
    else if (dn && cur != '0)  return cur - 1'b1;
    else                       return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     step <= INIT;
    else if (load)  step <= INIT;
    else            step <= sat_next(step, inc, dec);
  end

endmodule

// File: rtl/ocd_pin_force.sv
module ocd_pin_force
  import ocd_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int DQS_W = 2
) (
  input  cal_mode_e        mode,
  input  logic             rdqs_en,
  output logic [DQ_W-1:0]  dq_oe,
  output logic [DQ_W-1:0]  dq_lvl,
  output logic [DQS_W-1:0] dqs_oe,
  output logic [DQS_W-1:0] dqs_lvl,
  output logic [DQS_W-1:0] dqsn_lvl,
  output logic [DQS_W-1:0] rdqs_oe,
  output logic [DQS_W-1:0] rdqs_lvl
);

  logic drive, hi;

  assign hi    = (mode == CM_DRV_HI);
  assign drive = hi || (mode == CM_DRV_LO);

  for (genvar i = 0; i < DQ_W; i++) begin : g_dq
    assign dq_oe[i]  = drive;
    assign dq_lvl[i] = drive && hi;
  end

  for (genvar s = 0; s < DQS_W; s++) begin : g_dqs
    assign dqs_oe[s]   = drive;
    assign dqs_lvl[s]  = drive && hi;
    assign dqsn_lvl[s] = drive && !hi;
    assign rdqs_oe[s]  = drive && rdqs_en;
    assign rdqs_lvl[s] = drive && rdqs_en && hi;
  end

endmodule

// File: rtl/ocd_drv_cal.sv
module ocd_drv_cal
  import ocd_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int DQS_W     = 2,
  parameter int STEPS     = 8,
  parameter int DFLT_STEP = 4,
  localparam int STEP_W   = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emr_wr,
  input  logic [2:0]        cal_field,
  input  logic              rdqs_en_in,
  input  logic              half_in,
  input  logic              bl4_in,
  input  logic              beat_vld,
  input  logic              beat_bit,
  output logic [DQ_W-1:0]   dq_oe,
  output logic [DQ_W-1:0]   dq_lvl,
  output logic [DQS_W-1:0]  dqs_oe,
  output logic [DQS_W-1:0]  dqs_lvl,
  output logic [DQS_W-1:0]  dqsn_lvl,
  output logic [DQS_W-1:0]  rdqs_oe,
  output logic [DQS_W-1:0]  rdqs_lvl,
  output logic [STEP_W-1:0] pu_step,
  output logic [STEP_W-1:0] pd_step,
  output logic              adj_active,
  output logic              bl_err,
  output logic              dflt_na
);

  localparam int BEATS = 4;
  localparam int NCTR  = 2;

  cal_mode_e        mode;
  logic             rdqs_en_q;
  logic             dflt_load;
  logic             adj_reject;
  logic             code_vld;
  logic [BEATS-1:0] code;
  step_op_e         pu_op, pd_op;
  logic             pu_inc, pu_dec, pd_inc, pd_dec;
  logic [NCTR-1:0]  inc_v, dec_v;
  logic [STEP_W-1:0] step_v [NCTR];

  ocd_mode_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr(emr_wr), .field(cal_field),
    .rdqs_in(rdqs_en_in), .half(half_in), .bl4(bl4_in),
    .mode(mode), .rdqs_en_q(rdqs_en_q), .err_q(bl_err), .na_q(dflt_na),
    .dflt_load(dflt_load), .adj_reject(adj_reject)
  );

  assign adj_active = (mode == CM_ADJ);

  ocd_code_cap #(.BEATS(BEATS)) u_cap (
    .clk(clk), .rst_n(rst_n), .arm(adj_active), .beat_vld(beat_vld),
    .beat_bit(beat_bit), .code_vld(code_vld), .code(code)
  );

  // Pull-up pair is the first two beats, pull-down the last two.
  assign pu_op  = pair_to_op(code[3:2]);
  assign pd_op  = pair_to_op(code[1:0]);
  assign pu_inc = code_vld && (pu_op == SO_UP);
  assign pu_dec = code_vld && (pu_op == SO_DOWN);
  assign pd_inc = code_vld && (pd_op == SO_UP);
  assign pd_dec = code_vld && (pd_op == SO_DOWN);
  assign inc_v  = {pd_inc, pu_inc};
  assign dec_v  = {pd_dec, pu_dec};

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    ocd_step_ctr #(.STEPS(STEPS), .DFLT(DFLT_STEP)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(dflt_load),
      .inc(inc_v[g]), .dec(dec_v[g]), .step(step_v[g])
    );
  end

  assign pu_step = step_v[0];
  assign pd_step = step_v[1];

  ocd_pin_force #(.DQ_W(DQ_W), .DQS_W(DQS_W)) u_pins (
    .mode(mode), .rdqs_en(rdqs_en_q),
    .dq_oe(dq_oe), .dq_lvl(dq_lvl), .dqs_oe(dqs_oe), .dqs_lvl(dqs_lvl),
    .dqsn_lvl(dqsn_lvl), .rdqs_oe(rdqs_oe), .rdqs_lvl(rdqs_lvl)
  );

endmodule

// File: rtl/ocd_drv_cal_chk.sv
module ocd_drv_cal_chk #(
  parameter int DQ_W   = 16,
  parameter int DQS_W  = 2,
  parameter int STEP_W = 3,
  parameter int STEPS  = 8,
  parameter int DFLT   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              emr_wr,
  input logic [2:0]        cal_field,
  input logic              half_in,
  input logic [DQ_W-1:0]   dq_oe,
  input logic [DQS_W-1:0]  dqs_oe,
  input logic [DQS_W-1:0]  dqs_lvl,
  input logic [DQS_W-1:0]  dqsn_lvl,
  input logic [DQS_W-1:0]  rdqs_oe,
  input logic [STEP_W-1:0] pu_step,
  input logic [STEP_W-1:0] pd_step,
  input logic              adj_active,
  input logic              bl_err,
  input logic              rdqs_en_q,
  input logic              code_vld,
  input logic              pu_inc,
  input logic              pd_dec,
  input logic              dflt_load
);

  localparam logic [STEP_W-1:0] TOP  = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] INIT = STEP_W'(DFLT);

  p_adj_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adj_active |-> (dq_oe == '0));

  p_strobe_compl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe != '0) |-> (dqsn_lvl == ~dqs_lvl));

  p_rdqs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdqs_en_q |-> (rdqs_oe == '0));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bl_err |=> bl_err);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_inc && !dflt_load && pu_step == TOP) |=> (pu_step == TOP));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_dec && !dflt_load && pd_step == '0) |=> (pd_step == '0));

  p_exit_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (emr_wr && cal_field == 3'b000 && !code_vld) |=>
      ($stable(pu_step) && $stable(pd_step)));

  p_dflt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (emr_wr && cal_field == 3'b111 && !half_in) |=>
      (pu_step == INIT && pd_step == INIT));

endmodule

bind ocd_drv_cal ocd_drv_cal_chk #(
  .DQ_W(DQ_W), .DQS_W(DQS_W), .STEP_W(STEP_W), .STEPS(STEPS), .DFLT(DFLT_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .emr_wr(emr_wr), .cal_field(cal_field),
  .half_in(half_in), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_lvl(dqs_lvl),
  .dqsn_lvl(dqsn_lvl), .rdqs_oe(rdqs_oe), .pu_step(pu_step), .pd_step(pd_step),
  .adj_active(adj_active), .bl_err(bl_err), .rdqs_en_q(rdqs_en_q),
  .code_vld(code_vld), .pu_inc(pu_inc), .pd_dec(pd_dec), .dflt_load(dflt_load)
);

// File: tb/tb_ocd_drv_cal.sv
module tb_ocd_drv_cal;

  localparam int DQ_W = 16;
  localparam int DQS_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic emr_wr = 1'b0;
  logic [2:0] cal_field = 3'b000;
  logic rdqs_en_in = 1'b0, half_in = 1'b0, bl4_in = 1'b0;
  logic beat_vld = 1'b0, beat_bit = 1'b0;
  logic [DQ_W-1:0] dq_oe, dq_lvl;
  logic [DQS_W-1:0] dqs_oe, dqs_lvl, dqsn_lvl, rdqs_oe, rdqs_lvl;
  logic [2:0] pu_step, pd_step;
  logic adj_active, bl_err, dflt_na;

  ocd_drv_cal dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench model: 0 idle, 1 high, 2 low, 3 adjust
  int m_mode = 0, m_pu = 4, m_pd = 4;
  bit m_err = 0, m_na = 0, m_rd = 0;

  function automatic int step_after(int s, bit [1:0] pair);
    int r = s;
    if (pair == 2'b01 && s < 7) r = s + 1;
    if (pair == 2'b10 && s > 0) r = s - 1;
    return r;
  endfunction

  task automatic cmp(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit drv = (m_mode == 1 || m_mode == 2);
    bit hi = (m_mode == 1);
    cmp({req, " pu_step"}, pu_step, m_pu);
    cmp({req, " pd_step"}, pd_step, m_pd);
    cmp({req, " bl_err R5"}, bl_err, m_err);
    cmp({req, " dflt_na R9"}, dflt_na, m_na);
    cmp({req, " adj_active"}, adj_active, m_mode == 3);
    cmp({req, " dq_oe R2"}, dq_oe, drv ? {DQ_W{1'b1}} : '0);
    cmp({req, " dq_lvl R3"}, dq_lvl, (drv && hi) ? {DQ_W{1'b1}} : '0);
    cmp({req, " dqs_lvl R2"}, {dqs_oe, dqs_lvl},
        {(drv ? {DQS_W{1'b1}} : {DQS_W{1'b0}}), ((drv && hi) ? {DQS_W{1'b1}} : {DQS_W{1'b0}})});
    cmp({req, " dqsn_lvl R3"}, dqsn_lvl, (drv && !hi) ? {DQS_W{1'b1}} : '0);
    cmp({req, " rdqs R4"}, {rdqs_oe, rdqs_lvl},
        {((drv && m_rd) ? {DQS_W{1'b1}} : {DQS_W{1'b0}}),
         ((drv && m_rd && hi) ? {DQS_W{1'b1}} : {DQS_W{1'b0}})});
  endtask

  task automatic emr(input bit [2:0] f, input bit rd, input bit hf, input bit b4);
    @(negedge clk);
    emr_wr = 1'b1; cal_field = f; rdqs_en_in = rd; half_in = hf; bl4_in = b4;
    @(negedge clk);
    emr_wr = 1'b0;
    m_rd = rd;
    case (f)
      3'b000: m_mode = 0;
      3'b001: m_mode = 1;
      3'b010: m_mode = 2;
      3'b100: if (b4) m_mode = 3; else m_err = 1;
      3'b111: begin
        m_mode = 0;
        m_na = hf;
        if (!hf) begin m_pu = 4; m_pd = 4; end
      end
      default: ;
    endcase
  endtask

  task automatic send_code(input bit [3:0] c);
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      beat_vld = 1'b1; beat_bit = c[i];
    end
    @(negedge clk);
    beat_vld = 1'b0;
    @(negedge clk);
    if (m_mode == 3) begin
      m_pu = step_after(m_pu, c[3:2]);
      m_pd = step_after(m_pd, c[1:0]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    emr(3'b001, 1'b1, 1'b0, 1'b1); check_all("R2 drive high rdqs on");
    emr(3'b010, 1'b1, 1'b0, 1'b1); check_all("R3 drive low rdqs on");
    emr(3'b001, 1'b0, 1'b0, 1'b1); check_all("R4 drive high rdqs off");

    emr(3'b100, 1'b0, 1'b0, 1'b0); check_all("R5 adjust rejected");
    emr(3'b100, 1'b0, 1'b0, 1'b1); check_all("R5 adjust accepted");

    send_code(4'b0110); check_all("R6 pu up pd down");
    send_code(4'b1101); check_all("R11 pu hold pd up");
    send_code(4'b0011); check_all("R11 pd hold");
    for (int k = 0; k < 6; k++) send_code(4'b0110);
    check_all("R7 at limits");
    send_code(4'b0110); check_all("R7 saturate");
    send_code(4'b1001); check_all("R6 reverse");

    emr(3'b011, 1'b0, 1'b0, 1'b1); check_all("R10 code 011");
    emr(3'b101, 1'b0, 1'b1, 1'b1); check_all("R10 code 101");
    emr(3'b110, 1'b0, 1'b0, 1'b0); check_all("R10 code 110");
    emr(3'b000, 1'b0, 1'b0, 1'b1); check_all("R8 exit keeps");
    send_code(4'b0101); check_all("R6 beats ignored idle");
    emr(3'b111, 1'b0, 1'b1, 1'b1); check_all("R9 half na");
    emr(3'b111, 1'b0, 1'b0, 1'b1); check_all("R9 default load");

    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 4) begin
        emr(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 5) != 0));
        check_all("R2-random write");
      end else begin
        if (m_mode != 3 && sel < 8) emr(3'b100, 1'($urandom), 1'b0, 1'b1);
        send_code(4'($urandom));
        check_all("R6 random code");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule